// File: doc/BRIEF.md
# DRAM Rank Address Decoder

This block turns a physical memory address into the channel and rank that hold it, for a two-channel DDR2 memory map with four ranks on each channel. Software programs, per channel, four cumulative top-of-rank boundaries and a page-size code for every rank through a small write port. A lookup presents an address. One cycle later the block returns a hit flag, the channel, the rank index and the rank's page-size code.

Boundaries count in 32 MiB units, which is address bits 32:25. Each boundary is the cumulative top of its rank, so a rank whose boundary does not rise above its predecessor holds no memory. The block also compares the two channels' settings all the time. When every boundary and every rank code match, it reports interleaved mode. In that mode only channel 0's boundaries form the map, each counting double, and address bit 7 picks the channel. Otherwise channel 1's ranks sit above channel 0's in the address map.

Top module: `dram_rank_decoder`

## Requirements
- R1: After reset all boundaries and rank codes are zero, `res_valid` and `res_hit` are 0, and `ilv_mode` is 1 because the two channels match. Every lookup then misses.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next clock edge. `cfg_idx[3]` selects the channel and `cfg_idx[2:0]` selects the register. Values 0 to 3 are the boundaries of ranks 0 to 3. Value 4 is the code register for ranks 0 and 1, and value 5 is the code register for ranks 2 and 3. In a code register, bits 2:0 hold the even rank's code and bits 6:4 hold the odd rank's code. Writes with `cfg_idx[2:0]` equal to 6 or 7 change nothing.
- R3: `res_valid` equals `lk_valid` delayed by one clock. The result fields describe the address presented in that earlier cycle. While `res_valid` is 0, `res_hit` is 0.
- R4: In non-interleaved mode, with unit u = `lk_addr[32:25]`, channel 0 rank r is selected when u is at least the boundary of rank r-1 (0 for rank 0) and below the boundary of rank r.
- R5: In non-interleaved mode, channel 1's ranks are placed above channel 0's top boundary. Channel 1 rank r covers u from T0 + B1[r-1] up to, but not including, T0 + B1[r], where T0 is channel 0's rank-3 boundary.
- R6: A rank whose boundary is not greater than the boundary before it (or is zero, for rank 0) is empty and is never returned.
- R7: Codes 3'b010 (4 KB), 3'b011 (8 KB) and 3'b100 (16 KB) mark a populated rank, and `res_page` returns that code on a hit. Code 3'b000 and every other code make the rank's span return a miss.
- R8: An address at or above the top of the map, or one in a span that is not populated, gives `res_hit` = 0 with `res_chan`, `res_rank` and `res_page` all zero.
- R9: `ilv_mode` is 1 exactly when all four boundaries and all four rank codes are equal on the two channels. Bits 7 and 3 of the code registers are not stored and play no part.
- R10: In interleaved mode each channel-0 boundary is doubled before it is compared with u. Channel 0's ranks and codes are used, and `res_chan` equals `lk_addr[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register select: channel in bit 3, register in bits 2:0 |
| cfg_wdata | input | 8 | Configuration write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 33 | Physical address to decode |
| res_valid | output | 1 | Lookup result valid, one cycle after the request |
| res_hit | output | 1 | Address lies in a populated rank |
| res_chan | output | 1 | Channel of the selected rank |
| res_rank | output | 2 | Rank index within the channel |
| res_page | output | 3 | Page-size code of the selected rank |
| ilv_mode | output | 1 | Channels configured identically (interleaved) |

## Verification
The assertions assume that a lookup is never issued in the same cycle as a configuration write, since the result would then mix the old map with the new one. They also assume that boundaries never decrease within a channel, because only then do the rank spans follow the requirements exactly. The stimulus writes the whole map first and only then starts lookups, and every map it programs rises monotonically. Empty ranks appear in the map only as repeated values, never as decreasing ones.

// File: rtl/rank_dec_pkg.sv
package rank_dec_pkg;

    localparam int CH_N     = 2;
    localparam int RK_N     = 4;
    localparam int BND_W    = 8;
    localparam int CODE_W   = 3;
    localparam int ODD_LSB  = 4;
    localparam int CH_W     = $clog2(CH_N);
    localparam int RK_W     = $clog2(RK_N);
    localparam int PAIR_N   = RK_N / 2;
    localparam int SEL_W    = 3;
    localparam int IDX_W    = CH_W + SEL_W;
    localparam int SPAN_W   = BND_W + CH_W;
    localparam int FLAT_N   = CH_N * RK_N;
    localparam int FLAT_W   = CH_W + RK_W;

    typedef logic [BND_W-1:0]  bnd_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SPAN_W-1:0] span_t;

    typedef logic [CH_N-1:0][RK_N-1:0][BND_W-1:0]  bnd_arr_t;
    typedef logic [CH_N-1:0][RK_N-1:0][CODE_W-1:0] code_arr_t;

    typedef enum logic [CODE_W-1:0] {
        PG_NONE = 3'b000,
        PG_4K   = 3'b010,
        PG_8K   = 3'b011,
        PG_16K  = 3'b100
    } page_code_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
        logic [RK_W-1:0] rk;
        code_t           page;
    } lk_res_t;

    function automatic logic code_ok(input code_t c);
        return (c == PG_4K) || (c == PG_8K) || (c == PG_16K);
    endfunction

endpackage

// File: rtl/rank_cfg_regs.sv
module rank_cfg_regs
    import rank_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [BND_W-1:0] wdata,
    output bnd_arr_t         bnd,
    output code_arr_t        code
);

    logic [CH_W-1:0]  ch_sel;
    logic [SEL_W-1:0] reg_sel;

    assign ch_sel  = idx[IDX_W-1 -: CH_W];
    assign reg_sel = idx[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd  <= '0;
            code <= '0;
        end else if (we) begin
            for (int c = 0; c < CH_N; c++) begin
                for (int r = 0; r < RK_N; r++) begin
                    if (ch_sel == CH_W'(c) && reg_sel == SEL_W'(r))
                        bnd[c][r] <= wdata;
                    if (ch_sel == CH_W'(c) && reg_sel == SEL_W'(RK_N + r / 2)) begin
                        if ((r % 2) == 1)
                            code[c][r] <= wdata[ODD_LSB +: CODE_W];
                        else
                            code[c][r] <= wdata[CODE_W-1:0];
                    end
                end
            end
        end
    end

    // R2: a boundary write to channel 0 rank 0 lands on the next edge
    assert_bnd_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IDX_W'(0)) |=> (bnd[0][0] == $past(wdata)));

endmodule

// File: rtl/rank_ilv_detect.sv
module rank_ilv_detect
    import rank_dec_pkg::*;
(
    input  bnd_arr_t  bnd,
    input  code_arr_t code,
    output logic      ilv
);

    logic [CH_N-1:0] same;

    assign same[0] = 1'b1;

    for (genvar c = 1; c < CH_N; c++) begin : g_cmp
        assign same[c] = (bnd[c] == bnd[0]) && (code[c] == code[0]);
    end

    assign ilv = &same;

endmodule

// File: rtl/rank_span_lookup.sv
module rank_span_lookup
    import rank_dec_pkg::*;
#(
    parameter int ADDR_W  = 33,
    parameter int ILV_BIT = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  bnd_arr_t          bnd,
    input  code_arr_t         code,
    input  logic              ilv,
    output lk_res_t           res
);

    localparam int GRAIN_LSB = ADDR_W - BND_W;

    span_t                    unit;
    logic [CH_N-1:0][SPAN_W-1:0] ch_base;
    logic [FLAT_N-1:0]        cand;
    logic                     found;
    logic [FLAT_W-1:0]        sel;
    logic [CH_W-1:0]          sel_ch;
    logic [RK_W-1:0]          sel_rk;
    code_t                    sel_code;

    assign unit = SPAN_W'(addr[ADDR_W-1:GRAIN_LSB]);

    // channel c starts where channel c-1 ends (non-interleaved map)
    always_comb begin
        ch_base[0] = '0;
        for (int c = 1; c < CH_N; c++)
            ch_base[c] = ch_base[c-1] + SPAN_W'(bnd[c-1][RK_N-1]);
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam bit IS_CH0 = (c == 0);
        for (genvar r = 0; r < RK_N; r++) begin : g_rk
            bnd_t  prev;
            span_t top;
            logic  nonempty;
            if (r == 0) begin : g_first
                assign prev = '0;
            end else begin : g_next
                assign prev = bnd[c][r-1];
            end
            assign nonempty = bnd[c][r] > prev;
            assign top = ilv ? (SPAN_W'(bnd[c][r]) << CH_W)
                             : ch_base[c] + SPAN_W'(bnd[c][r]);
            assign cand[c*RK_N + r] = nonempty && (IS_CH0 || !ilv) && (unit < top);
        end
    end

    // lowest candidate wins: with rising boundaries that is the covering rank
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = FLAT_N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                sel   = FLAT_W'(i);
            end
        end
    end

    assign sel_ch   = sel[FLAT_W-1 -: CH_W];
    assign sel_rk   = sel[RK_W-1:0];
    assign sel_code = code[sel_ch][sel_rk];

    always_comb begin
        res = '0;
        if (found && code_ok(sel_code)) begin
            res.hit  = 1'b1;
            res.ch   = ilv ? addr[ILV_BIT +: CH_W] : sel_ch;
            res.rk   = sel_rk;
            res.page = sel_code;
        end
    end

endmodule

// File: rtl/dram_rank_decoder.sv
module dram_rank_decoder
    import rank_dec_pkg::*;
#(
    parameter int ADDR_W  = 33,
    parameter int ILV_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_chan,
    output logic [1:0]        res_rank,
    output logic [2:0]        res_page,
    output logic              ilv_mode
);

    bnd_arr_t  bnd;
    code_arr_t code;
    lk_res_t   lk_res;
    lk_res_t   res_q;
    logic      valid_q;

    rank_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .bnd   (bnd),
        .code  (code)
    );

    rank_ilv_detect u_ilv (
        .bnd  (bnd),
        .code (code),
        .ilv  (ilv_mode)
    );

    rank_span_lookup #(
        .ADDR_W  (ADDR_W),
        .ILV_BIT (ILV_BIT)
    ) u_lookup (
        .addr (lk_addr),
        .bnd  (bnd),
        .code (code),
        .ilv  (ilv_mode),
        .res  (lk_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= lk_valid;
            res_q   <= lk_valid ? lk_res : '0;
        end
    end

    assign res_valid = valid_q;
    assign res_hit   = res_q.hit;
    assign res_chan  = res_q.ch;
    assign res_rank  = res_q.rk;
    assign res_page  = res_q.page;

    // R3: one-cycle result latency
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R3: no request, no result
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && !res_hit));

    // R7: a hit always carries a populated page code
    assert_page_code_R7: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_page == 3'b010 || res_page == 3'b011 || res_page == 3'b100));

    // R8: a miss reports all-zero location fields
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (!res_chan && res_rank == 2'd0 && res_page == 3'd0));

    // R10: interleaved hits take their channel from the address
    assert_ilv_chan_R10: assert property (@(posedge clk) disable iff (rst)
        (res_hit && $past(ilv_mode)) |-> (res_chan == $past(lk_addr[ILV_BIT])));

endmodule

// File: tb/dram_rank_decoder_tb_top.sv
module dram_rank_decoder_tb_top;

    localparam int GRAIN = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic        lk_valid;
    logic [32:0] lk_addr;
    logic        res_valid, res_hit, res_chan, ilv_mode;
    logic [1:0]  res_rank;
    logic [2:0]  res_page;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dram_rank_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_chan(res_chan),
        .res_rank(res_rank), .res_page(res_page), .ilv_mode(ilv_mode)
    );

    typedef struct packed {
        logic [7:0] u;
        logic       a7;
        logic [3:0] tag;
        logic       hit;
        logic       ch;
        logic [1:0] rk;
        logic [2:0] pg;
    } vec_t;

    // map A (non-interleaved): ch0 bnd 4,4,10,12 codes 2,3,4,5; ch1 bnd 2,5,5,8 codes 3,2,0,4
    localparam vec_t TBL [13] = '{
        '{8'd0,   1'b0, 4'd4, 1'b1, 1'b0, 2'd0, 3'd2},  // R4
        '{8'd3,   1'b1, 4'd4, 1'b1, 1'b0, 2'd0, 3'd2},  // R4, bit 7 ignored
        '{8'd4,   1'b0, 4'd6, 1'b1, 1'b0, 2'd2, 3'd4},  // R6 empty rank 1 skipped
        '{8'd9,   1'b0, 4'd4, 1'b1, 1'b0, 2'd2, 3'd4},  // R4
        '{8'd10,  1'b0, 4'd7, 1'b0, 1'b0, 2'd0, 3'd0},  // R7 reserved code
        '{8'd12,  1'b0, 4'd5, 1'b1, 1'b1, 2'd0, 3'd3},  // R5
        '{8'd13,  1'b1, 4'd5, 1'b1, 1'b1, 2'd0, 3'd3},  // R5
        '{8'd14,  1'b0, 4'd5, 1'b1, 1'b1, 2'd1, 3'd2},  // R5
        '{8'd16,  1'b0, 4'd5, 1'b1, 1'b1, 2'd1, 3'd2},  // R5
        '{8'd17,  1'b0, 4'd6, 1'b1, 1'b1, 2'd3, 3'd4},  // R6 ch1 rank 2 empty
        '{8'd19,  1'b0, 4'd5, 1'b1, 1'b1, 2'd3, 3'd4},  // R5
        '{8'd20,  1'b0, 4'd8, 1'b0, 1'b0, 2'd0, 3'd0},  // R8 top
        '{8'd255, 1'b1, 4'd8, 1'b0, 1'b0, 2'd0, 3'd0}   // R8
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // result packed as {hit, chan, rank, page}
    task automatic look(input string tag, input logic [7:0] u, input logic a7,
                        input logic [6:0] exp);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = (33'(u) << GRAIN) | (33'(a7) << 7);
        @(negedge clk);
        lk_valid = 1'b0;
        check(tag, 32'({res_hit, res_chan, res_rank, res_page}), 32'(exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        lk_valid = 1'b0; lk_addr = '0;
        do_reset();

        // R1 reset state
        check("R1", 32'(res_valid), 0);
        check("R1", 32'(res_hit), 0);
        check("R1", 32'(ilv_mode), 1);
        look("R1", 8'd0, 1'b0, 7'b0);

        // R3 latency: valid tracks the request one cycle later
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = '0;
        @(negedge clk);
        lk_valid = 1'b0;
        check("R3", 32'(res_valid), 1);
        @(negedge clk);
        check("R3", 32'(res_valid), 0);

        // map A via the register layout of R2
        wr(4'h0, 8'd4);  wr(4'h1, 8'd4);  wr(4'h2, 8'd10); wr(4'h3, 8'd12);
        wr(4'h4, 8'h32); wr(4'h5, 8'h54);
        wr(4'h8, 8'd2);  wr(4'h9, 8'd5);  wr(4'hA, 8'd5);  wr(4'hB, 8'd8);
        wr(4'hC, 8'h23); wr(4'hD, 8'h40);
        check("R9", 32'(ilv_mode), 0);

        for (int i = 0; i < 13; i++)
            look(tag_name(TBL[i].tag), TBL[i].u, TBL[i].a7,
                 {TBL[i].hit, TBL[i].ch, TBL[i].rk, TBL[i].pg});

        // R2 ignored register selects 6 and 7 on both channels
        wr(4'h6, 8'hFF); wr(4'hE, 8'hFF); wr(4'h7, 8'h00);
        check("R2", 32'(ilv_mode), 0);
        look("R2", 8'd4,  1'b0, {1'b1, 1'b0, 2'd2, 3'd4});
        look("R2", 8'd20, 1'b0, 7'b0);
        look("R2", 8'd10, 1'b0, 7'b0);

        // map B: identical channels, reserved bits differ on ch1
        wr(4'h0, 8'd3);  wr(4'h1, 8'd6);  wr(4'h2, 8'd6);  wr(4'h3, 8'd7);
        wr(4'h4, 8'h43); wr(4'h5, 8'h20);
        wr(4'h8, 8'd3);  wr(4'h9, 8'd6);  wr(4'hA, 8'd6);  wr(4'hB, 8'd7);
        wr(4'hC, 8'hCB); wr(4'hD, 8'h20);
        check("R9", 32'(ilv_mode), 1);

        // R10 doubled boundaries 6,12,12,14; channel from bit 7
        look("R10", 8'd5,  1'b1, {1'b1, 1'b1, 2'd0, 3'd3});
        look("R10", 8'd6,  1'b0, {1'b1, 1'b0, 2'd1, 3'd4});
        look("R10", 8'd11, 1'b1, {1'b1, 1'b1, 2'd1, 3'd4});
        look("R10", 8'd12, 1'b1, {1'b1, 1'b1, 2'd3, 3'd2});
        look("R8",  8'd14, 1'b1, 7'b0);

        // R9 one boundary differs: back to stacked map
        wr(4'hB, 8'd8);
        check("R9", 32'(ilv_mode), 0);
        look("R4", 8'd5, 1'b1, {1'b1, 1'b0, 2'd1, 3'd4});
        look("R5", 8'd7, 1'b0, {1'b1, 1'b1, 2'd0, 3'd3});
        look("R8", 8'd15, 1'b0, 7'b0);

        // R1 reset clears the map
        do_reset();
        check("R1", 32'(ilv_mode), 1);
        look("R1", 8'd4, 1'b0, 7'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule